// File: doc/BRIEF.md
# Jump Target Address Sequencer

This block works out where a jump instruction sends execution in a processor with a 16-bit program counter and an 8-bit program bank, giving a 24-bit address. The issuing logic gives it the jump kind, the operand bytes and the current program bank. A request is accepted with a one-cycle strobe. Absolute and absolute long jumps resolve straight from the operand. The indirect forms read a pointer from memory one byte at a time over a simple port made of an address, a read strobe, a data byte and a ready signal.

The pointer always lives in bank zero, whatever data bank is in use. Its address advances by one for each byte and wraps inside the 64K bank. Only the long kinds can move execution to another bank. A compatibility mode models a part with a reduced address space: the bank output is forced to zero for every kind, so the jump lands where the 16-bit form would.

When the target is settled, `done` pulses for one cycle and `newPc`/`newBank` hold the result until the next jump. No flags or other registers are involved.

Top module: `jump_target_seq`

## Requirements
- R1: After reset, `busy`, `done` and `memRd` are 0, and `newPc` and `newBank` are 0.
- R2: Kind 0 (absolute) sets `newPc` to `operand[15:0]` and `newBank` to `curBank`, issues no memory read, and pulses `done` in the cycle after acceptance.
- R3: Kind 2 (absolute long) sets `newPc` to `operand[15:0]` and `newBank` to `operand[23:16]`, issues no read, and pulses `done` in the cycle after acceptance.
- R4: Kind 1 (absolute indirect) reads two bytes at pointer P and P+1. The first byte goes to `newPc[7:0]` and the second to `newPc[15:8]`. `newBank` becomes `curBank` as sampled at acceptance.
- R5: Kind 3 (absolute indirect long) reads three bytes at P, P+1 and P+2. They give `newPc[7:0]`, `newPc[15:8]` and `newBank`, in that order.
- R6: Every read address has bits [23:16] equal to zero. Its low 16 bits start at `operand[15:0]` and step by one modulo 65536 (0xFFFF is followed by 0x0000).
- R7: A byte is taken only in a cycle where `memReady` is 1. While `memReady` is 0, `memRd` stays high and `memAddr` stays stable.
- R8: `done` is high for exactly one cycle. For indirect kinds, that cycle directly follows the clock edge that captures the last byte, and `busy` is low in it.
- R9: `busy` is high from acceptance of an indirect jump until its last byte is captured. A `reqValid` seen while `busy` is high has no effect on the result or on later reads.
- R10: With `compatMode` at 1 (sampled at acceptance), `newBank` is 0 for every kind. The program counter and the read sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Jump request strobe |
| reqKind | input | 2 | 0 absolute, 1 indirect, 2 long, 3 indirect long |
| operand | input | 24 | [15:0] address or pointer, [23:16] bank byte for long kind |
| curBank | input | 8 | Current program bank |
| compatMode | input | 1 | Reduced-address mode, bank forced to zero |
| memAddr | output | 24 | Pointer byte address |
| memRd | output | 1 | Read strobe |
| memData | input | 8 | Read data |
| memReady | input | 1 | Read completes this cycle |
| busy | output | 1 | Indirect sequence in progress |
| done | output | 1 | One-cycle result pulse |
| newPc | output | 16 | Resolved program counter |
| newBank | output | 8 | Resolved program bank |

## Verification
All four kinds run with random operands, random current banks and compatibility on and off. Memory returns an address-derived byte, so a wrong byte order, a wrong pointer step or a bank leaking into the wrong kind each yields a different target. Pointers at 0xFFFF and 0xFFFE test the bank-zero wrap. A fixed three-cycle stall per byte pins the `done` cycle exactly, and random ready gaps exercise waiting. A foreign request injected mid-sequence must leave the result and the read count untouched.

// File: rtl/jts_pkg.sv
`timescale 1ns/1ps
package jts_pkg;
  typedef enum logic [1:0] {
    JK_ABS      = 2'd0,
    JK_IND      = 2'd1,
    JK_LONG     = 2'd2,
    JK_IND_LONG = 2'd3
  } jumpKind_e;

  typedef struct packed {
    logic       loadDirect;
    logic       startRead;
    logic       capture;
    logic       finish;
    logic [1:0] byteSel;
  } seqStrobes_t;
endpackage

// File: rtl/jts_ctrl.sv
`timescale 1ns/1ps
module jts_ctrl
  import jts_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        memReady,
  output logic        busy,
  output logic        memRd,
  output seqStrobes_t strb
);
  localparam int PTR_BYTES  = PC_W / DATA_W;
  localparam int LONG_BYTES = (PC_W + BANK_W) / DATA_W;

  typedef enum logic {ST_IDLE, ST_READ} state_e;

  state_e     state;
  logic [1:0] byteCnt;
  logic [1:0] lastIdx;
  jumpKind_e  kind;

  assign kind = jumpKind_e'(reqKind);

  always_comb begin
    strb = '0;
    strb.byteSel = byteCnt;
    if (state == ST_IDLE && reqValid) begin
      if (kind == JK_IND || kind == JK_IND_LONG) strb.startRead = 1'b1;
      else strb.loadDirect = 1'b1;
    end
    if (state == ST_READ && memReady) begin
      strb.capture = 1'b1;
      strb.finish  = (byteCnt == lastIdx);
    end
  end

  assign busy  = (state == ST_READ);
  assign memRd = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
      lastIdx <= '0;
    end else if (strb.startRead) begin
      state   <= ST_READ;
      byteCnt <= '0;
      lastIdx <= (kind == JK_IND_LONG) ? 2'(LONG_BYTES - 1) : 2'(PTR_BYTES - 1);
    end else if (strb.capture) begin
      if (strb.finish) state <= ST_IDLE;
      else byteCnt <= byteCnt + 2'd1;
    end
  end
endmodule

// File: rtl/jts_datapath.sv
`timescale 1ns/1ps
module jts_datapath
  import jts_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobes_t              strb,
  input  logic [1:0]               reqKind,
  input  logic [PC_W+BANK_W-1:0]   operand,
  input  logic [BANK_W-1:0]        curBank,
  input  logic                     compatMode,
  input  logic [DATA_W-1:0]        memData,
  output logic [PC_W+BANK_W-1:0]   memAddr,
  output logic [PC_W-1:0]          newPc,
  output logic [BANK_W-1:0]        newBank,
  output logic                     done
);
  localparam int PTR_BYTES = PC_W / DATA_W;

  logic [PC_W-1:0]   ptrReg;
  logic [PC_W-1:0]   pcReg;
  logic [BANK_W-1:0] bankReg;
  logic              keepBank;
  logic              doneReg;
  jumpKind_e         kind;

  assign kind = jumpKind_e'(reqKind);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg   <= '0;
      pcReg    <= '0;
      bankReg  <= '0;
      keepBank <= 1'b1;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (strb.loadDirect) begin
        pcReg   <= operand[PC_W-1:0];
        if (compatMode)         bankReg <= '0;
        else if (kind == JK_LONG) bankReg <= operand[PC_W+BANK_W-1:PC_W];
        else                    bankReg <= curBank;
        doneReg <= 1'b1;
      end
      if (strb.startRead) begin
        ptrReg   <= operand[PC_W-1:0];
        bankReg  <= compatMode ? '0 : curBank;
        keepBank <= compatMode || (kind != JK_IND_LONG);
      end
      if (strb.capture) begin
        ptrReg <= ptrReg + PC_W'(1);
        if (int'(strb.byteSel) < PTR_BYTES)
          pcReg[int'(strb.byteSel)*DATA_W +: DATA_W] <= memData;
        else if (!keepBank)
          bankReg <= BANK_W'(memData);
        if (strb.finish) doneReg <= 1'b1;
      end
    end
  end

  assign memAddr = {{BANK_W{1'b0}}, ptrReg};
  assign newPc   = pcReg;
  assign newBank = bankReg;
  assign done    = doneReg;
endmodule

// File: rtl/jump_target_seq.sv
`timescale 1ns/1ps
module jump_target_seq
  import jts_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [1:0]             reqKind,
  input  logic [PC_W+BANK_W-1:0] operand,
  input  logic [BANK_W-1:0]      curBank,
  input  logic                   compatMode,
  output logic [PC_W+BANK_W-1:0] memAddr,
  output logic                   memRd,
  input  logic [DATA_W-1:0]      memData,
  input  logic                   memReady,
  output logic                   busy,
  output logic                   done,
  output logic [PC_W-1:0]        newPc,
  output logic [BANK_W-1:0]      newBank
);
  seqStrobes_t strb;

  jts_ctrl #(.PC_W(PC_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .memReady(memReady), .busy(busy), .memRd(memRd), .strb(strb)
  );

  jts_datapath #(.PC_W(PC_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqKind(reqKind),
    .operand(operand), .curBank(curBank), .compatMode(compatMode),
    .memData(memData), .memAddr(memAddr), .newPc(newPc),
    .newBank(newBank), .done(done)
  );
endmodule

// File: rtl/jts_checker.sv
`timescale 1ns/1ps
module jts_checker #(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [PC_W+BANK_W-1:0] memAddr,
  input logic                   memRd,
  input logic                   memReady,
  input logic                   busy,
  input logic                   done
);
  localparam int ADDR_W = PC_W + BANK_W;

  AST_PTR_BANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr[ADDR_W-1:PC_W] == '0)); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memReady) |=> (!memRd || memAddr[PC_W-1:0] == $past(memAddr[PC_W-1:0]) + PC_W'(1))); // R6

  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memReady) |=> (memRd && $stable(memAddr))); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R8
endmodule

bind jump_target_seq jts_checker #(.PC_W(PC_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sim_jump_target_seq.sv
`timescale 1ns/1ps
module sim_jump_target_seq;
  localparam int PERIOD = 10;
  localparam int QTR    = PERIOD / 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [23:0] operand = '0;
  logic [7:0]  curBank = '0;
  logic        compatMode = 1'b0;
  logic [23:0] memAddr;
  logic        memRd;
  logic [7:0]  memData;
  logic        memReady = 1'b0;
  logic        busy;
  logic        done;
  logic [15:0] newPc;
  logic [7:0]  newBank;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  jump_target_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .operand(operand), .curBank(curBank), .compatMode(compatMode),
    .memAddr(memAddr), .memRd(memRd), .memData(memData), .memReady(memReady),
    .busy(busy), .done(done), .newPc(newPc), .newBank(newBank)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign memData = memByte(memAddr[15:0]);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode 0: always ready, 1: random ready, 2: three stall cycles per byte
  task automatic runJump(input logic [1:0] kind, input logic [23:0] op, input logic [7:0] cb,
                         input bit cmp, input int mode, input bit poke);
    logic [15:0] base, expPc;
    logic [7:0]  expBank;
    logic [15:0] addrs [4];
    int reads, doneAt, waitCnt, nExp;
    string tag;
    base = op[15:0];
    nExp = (kind == 2'd1) ? 2 : (kind == 2'd3) ? 3 : 0;
    tag  = (kind == 2'd0) ? "R2" : (kind == 2'd1) ? "R4" : (kind == 2'd2) ? "R3" : "R5";
    if (nExp == 0) expPc = base;
    else expPc = {memByte(base + 16'd1), memByte(base)};
    if (cmp) expBank = 8'h00;
    else if (kind == 2'd2) expBank = op[23:16];
    else if (kind == 2'd3) expBank = memByte(base + 16'd2);
    else expBank = cb;
    reads = 0; doneAt = -1; waitCnt = 0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; operand = op; curBank = cb; compatMode = cmp; memReady = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (poke && i == 1) begin
        reqValid = 1'b1; reqKind = 2'd2; operand = 24'hABCDEF; curBank = 8'h77; compatMode = 1'b0;
      end
      memReady = 1'b0;
      if (memRd) begin
        case (mode)
          0: memReady = 1'b1;
          1: memReady = 1'($urandom % 2);
          default: memReady = (waitCnt == 3);
        endcase
        if (mode == 2) waitCnt = memReady ? 0 : waitCnt + 1;
      end
      if (i == 0 && nExp > 0) check(busy === 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
      #(QTR);
      if (memRd && memReady) begin
        if (reads < 4) addrs[reads] = memAddr[15:0];
        check(memAddr[23:16] == 8'h00, "R6 pointer bank", 32'(memAddr[23:16]), 32'd0);
        reads++;
      end
      if (done) begin
        doneAt = i;
        break;
      end
    end
    reqValid = 1'b0;
    check(doneAt >= 0, "R8 done seen", 32'(doneAt), 32'(nExp));
    if (mode == 0)
      check(doneAt == nExp, (nExp == 0) ? tag : "R8 done cycle", 32'(doneAt), 32'(nExp));
    else if (mode == 2)
      check(doneAt == 4 * nExp, "R7 stall timing", 32'(doneAt), 32'(4 * nExp));
    check(reads == nExp, poke ? "R9 read count" : tag, 32'(reads), 32'(nExp));
    for (int k = 0; k < nExp && k < reads; k++)
      check(addrs[k] == base + 16'(k), "R6 pointer step", 32'(addrs[k]), 32'(base + 16'(k)));
    check(newPc == expPc, poke ? "R9 pc" : tag, 32'(newPc), 32'(expPc));
    check(newBank == expBank, cmp ? "R10 bank" : tag, 32'(newBank), 32'(expBank));
    @(negedge clk);
    memReady = 1'b0;
    #(QTR);
    check(done == 1'b0 && busy == 1'b0 && memRd == 1'b0, "R8 single pulse",
          {29'd0, done, busy, memRd}, 32'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #(QTR);
    check(busy == 0 && done == 0 && memRd == 0, "R1 reset strobes", {29'd0, busy, done, memRd}, 32'd0);
    check(newPc == 16'h0 && newBank == 8'h0, "R1 reset result", {8'd0, newBank, newPc}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    // directed corners
    runJump(2'd0, 24'h123456, 8'h9A, 1'b0, 0, 1'b0);   // R2
    runJump(2'd2, 24'hFEA030, 8'h11, 1'b0, 0, 1'b0);   // R3
    runJump(2'd1, 24'h332000, 8'h44, 1'b0, 0, 1'b0);   // R4
    runJump(2'd3, 24'h552000, 8'h05, 1'b0, 0, 1'b0);   // R5
    runJump(2'd1, 24'h00FFFF, 8'h21, 1'b0, 0, 1'b0);   // R6 wrap
    runJump(2'd3, 24'h00FFFE, 8'h22, 1'b0, 0, 1'b0);   // R6 wrap
    runJump(2'd3, 24'h001234, 8'h66, 1'b0, 2, 1'b0);   // R7
    runJump(2'd1, 24'h004321, 8'h67, 1'b0, 2, 1'b0);   // R7
    runJump(2'd1, 24'h00ABCD, 8'h68, 1'b0, 0, 1'b1);   // R9
    runJump(2'd3, 24'h000F00, 8'h69, 1'b0, 0, 1'b1);   // R9
    runJump(2'd2, 24'hC0FFEE, 8'h12, 1'b1, 0, 1'b0);   // R10
    runJump(2'd3, 24'h004000, 8'h13, 1'b1, 0, 1'b0);   // R10
    runJump(2'd0, 24'h005555, 8'h14, 1'b1, 0, 1'b0);   // R10
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r;
      r = $urandom;
      runJump(2'(r[1:0]), 24'($urandom), 8'($urandom), ($urandom % 4) == 0,
              int'($urandom % 3), ($urandom % 5) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule